// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for every beat of a synchronous DRAM read or write burst. A start pulse captures a starting column, a 3-bit length code, an ordering select and the access direction. From the next cycle on, the block presents one column per beat and moves to the next column on each cycle in which the advance input is high. It raises a last-beat flag on the final beat of a fixed-length burst.

Two orderings are supported inside an aligned group of L columns. Sequential order counts the low log2(L) bits upward modulo L. Interleaved order XORs the start column with the beat index. A full-page burst walks the whole 256-column row, wrapping from the top column to column 0. It runs until it is stopped, and it always uses sequential order.

A stop input ends the burst at any cycle. A new start pulse on any cycle replaces the running burst. A single-write setting turns every write burst into a one-beat access, while reads keep the programmed length.

Top module: `burst_col_gen`

## Requirements
- R1: After reset `colValid` and `lastBeat` are 0.
- R2: In the cycle after `startPulse`, `colValid` is 1 and `colOut` equals the captured `startCol`. Length codes 0, 1, 2 and 3 give 1, 2, 4 and 8 beats, code 7 gives a full page, and codes 4 to 6 give a single beat.
- R3: With `interleaveSel`=0 and length L in {1,2,4,8}, beat k has the bits above log2(L) equal to the start column, and the low log2(L) bits equal to (start+k) mod L.
- R4: With `interleaveSel`=1 and L in {2,4,8}, the low log2(L) bits of beat k equal the start column's low bits XOR k, and the upper bits stay fixed.
- R5: During a burst, a cycle with `advance`=0 (and no stop or start) leaves `colOut` and `colValid` unchanged.
- R6: `lastBeat` is 1 exactly on beat L-1 of a fixed-length burst. Advancing on that beat makes `colValid` 0 in the next cycle.
- R7: For length code 7, beat k is (start+k) mod 256, so column 255 is followed by 0. `lastBeat` is never raised, and `interleaveSel` is ignored.
- R8: `terminate` high without `startPulse` makes `colValid` 0 in the next cycle.
- R9: `startPulse` during a running burst replaces it with the new burst, and it wins over `terminate` in the same cycle.
- R10: When `isWrite`=1 and `singleWrite`=1 the burst is one beat whatever the length code. When `isWrite`=0 the programmed length applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begin a new burst with the fields below |
| startCol | input | 8 | First column of the burst |
| lenCode | input | 3 | Burst length code (0:1, 1:2, 2:4, 3:8, 7:full page) |
| interleaveSel | input | 1 | 1 = interleaved order, 0 = sequential |
| isWrite | input | 1 | 1 = write burst, 0 = read burst |
| singleWrite | input | 1 | 1 = writes are single-beat |
| advance | input | 1 | Move to the next beat |
| terminate | input | 1 | Stop the current burst |
| colOut | output | 8 | Column of the current beat |
| colValid | output | 1 | A burst beat is being presented |
| lastBeat | output | 1 | Current beat is the final one |

## Verification
The hardest case to reach from the ports is the full-page wrap from column 255 to 0. It takes hundreds of consecutive advances with no stop and no restart, which random stimulus with frequent starts almost never produces. A directed full-page run therefore begins near the top of the row and advances across the wrap with the interleave select set. A second awkward case is a restart that lands on the same cycle as a stop or a last-beat advance. Directed steps place `startPulse` on exactly those cycles, and the random phase keeps mixing all three events.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  localparam int LEN_CODE_W = 3;
  localparam logic [LEN_CODE_W-1:0] LEN_CODE_PAGE = 3'd7;
  localparam logic [LEN_CODE_W-1:0] LEN_CODE_MAXFIX = 3'd3;

  typedef struct packed {
    logic load;
    logic step;
  } ctrlStb_t;
endpackage

// File: rtl/burst_col_ctrl.sv
module burst_col_ctrl
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startPulse,
  input  logic [LEN_CODE_W-1:0] lenCode,
  input  logic                  interleaveSel,
  input  logic                  isWrite,
  input  logic                  singleWrite,
  input  logic                  advance,
  input  logic                  terminate,
  input  logic                  beatAtEnd,
  output ctrlStb_t              stb,
  output logic [COL_W-1:0]      lenMask,
  output logic                  ilMode,
  output logic                  colValid,
  output logic                  lastBeat
);
  logic [COL_W-1:0] maskNext;
  logic             fullNext;
  logic             ilNext;
  logic             validQ;
  logic             fullQ;
  logic [COL_W-1:0] maskQ;
  logic             ilQ;

  // decode of the length fields at the start pulse
  always_comb begin
    maskNext = '0;
    fullNext = 1'b0;
    if (isWrite && singleWrite) begin
      maskNext = '0;
    end else if (lenCode == LEN_CODE_PAGE) begin
      maskNext = '1;
      fullNext = 1'b1;
    end else if (lenCode <= LEN_CODE_MAXFIX) begin
      maskNext = (COL_W'(1) << lenCode) - COL_W'(1);
    end
    ilNext = interleaveSel && !fullNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
      fullQ  <= 1'b0;
      maskQ  <= '0;
      ilQ    <= 1'b0;
    end else if (startPulse) begin
      validQ <= 1'b1;
      fullQ  <= fullNext;
      maskQ  <= maskNext;
      ilQ    <= ilNext;
    end else if (validQ && (terminate || (advance && lastBeat))) begin
      validQ <= 1'b0;
    end
  end

  assign lastBeat = validQ && !fullQ && beatAtEnd;
  assign colValid = validQ;
  assign lenMask  = maskQ;
  assign ilMode   = ilQ;

  assign stb.load = startPulse;
  assign stb.step = validQ && advance && !terminate && !startPulse && !lastBeat;

  AST_TERM_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (terminate && !startPulse) |=> !colValid); // R8
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (lastBeat && advance && !startPulse) |=> !colValid); // R6
  AST_PAGE_NO_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && lenCode == LEN_CODE_PAGE && !(isWrite && singleWrite)) |=> !lastBeat); // R7
endmodule

// File: rtl/burst_col_dp.sv
module burst_col_dp
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStb_t         stb,
  input  logic [COL_W-1:0] startCol,
  input  logic [COL_W-1:0] lenMask,
  input  logic             ilMode,
  output logic [COL_W-1:0] colOut,
  output logic             beatAtEnd
);
  logic [COL_W-1:0] startQ;
  logic [COL_W-1:0] beatQ;
  logic [COL_W-1:0] seqSum;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ <= '0;
      beatQ  <= '0;
    end else if (stb.load) begin
      startQ <= startCol;
      beatQ  <= '0;
    end else if (stb.step) begin
      beatQ  <= (beatQ + COL_W'(1)) & lenMask;
    end
  end

  assign seqSum    = startQ + beatQ;
  assign beatAtEnd = (beatQ == lenMask);

  // per-bit choice: fixed upper bits, ordered low bits
  for (genvar i = 0; i < COL_W; i++) begin : g_colBit
    always_comb begin
      if (!lenMask[i])  colOut[i] = startQ[i];
      else if (ilMode)  colOut[i] = startQ[i] ^ beatQ[i];
      else              colOut[i] = seqSum[i];
    end
  end

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    stb.step |=> ((colOut & ~lenMask) == $past(colOut & ~lenMask))); // R3
  AST_STEP_MOVES: assert property (@(posedge clk) disable iff (!rstN)
    (stb.step && lenMask != '0) |=> (colOut != $past(colOut))); // R4
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startPulse,
  input  logic [COL_W-1:0]      startCol,
  input  logic [LEN_CODE_W-1:0] lenCode,
  input  logic                  interleaveSel,
  input  logic                  isWrite,
  input  logic                  singleWrite,
  input  logic                  advance,
  input  logic                  terminate,
  output logic [COL_W-1:0]      colOut,
  output logic                  colValid,
  output logic                  lastBeat
);
  ctrlStb_t         stb;
  logic [COL_W-1:0] lenMask;
  logic             ilMode;
  logic             beatAtEnd;

  burst_col_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .lenCode(lenCode),
    .interleaveSel(interleaveSel), .isWrite(isWrite), .singleWrite(singleWrite),
    .advance(advance), .terminate(terminate), .beatAtEnd(beatAtEnd),
    .stb(stb), .lenMask(lenMask), .ilMode(ilMode),
    .colValid(colValid), .lastBeat(lastBeat)
  );

  burst_col_dp #(.COL_W(COL_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .startCol(startCol),
    .lenMask(lenMask), .ilMode(ilMode), .colOut(colOut), .beatAtEnd(beatAtEnd)
  );

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> (colValid && colOut == $past(startCol))); // R2
  AST_RESTART_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && terminate) |=> colValid); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (colValid && !advance && !terminate && !startPulse) |=> (colValid && $stable(colOut))); // R5
  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && isWrite && singleWrite) |=> lastBeat); // R10
endmodule

// File: tb/tb_burst_col_gen.sv
`timescale 1ns/1ps
module tb_burst_col_gen;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startPulse = 1'b0;
  logic [7:0] startCol = '0;
  logic [2:0] lenCode = '0;
  logic       interleaveSel = 1'b0;
  logic       isWrite = 1'b0;
  logic       singleWrite = 1'b0;
  logic       advance = 1'b0;
  logic       terminate = 1'b0;
  logic [7:0] colOut;
  logic       colValid;
  logic       lastBeat;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench model state
  bit mValid = 0;
  int mStart = 0;
  int mLen = 1;
  bit mFull = 0;
  bit mIl = 0;
  int mBeat = 0;

  always #2.5 clk = ~clk;

  burst_col_gen dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .startCol(startCol),
    .lenCode(lenCode), .interleaveSel(interleaveSel), .isWrite(isWrite),
    .singleWrite(singleWrite), .advance(advance), .terminate(terminate),
    .colOut(colOut), .colValid(colValid), .lastBeat(lastBeat)
  );

  function automatic int expCol(int st, int len, bit full, bit il, int beat);
    int m;
    if (full) return (st + beat) % 256;
    m = len - 1;
    if (il) return (st & ~m & 255) | ((st ^ beat) & m);
    return (st & ~m & 255) | ((st + beat) & m);
  endfunction

  function automatic int codeLen(int code);
    if (code <= 3) return 1 << code;
    return 1;
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic stepCyc(bit st, int col, int code, bit il, bit wr, bit sw,
                         bit adv, bit term, string tag);
    @(negedge clk);
    startPulse = st; startCol = col[7:0]; lenCode = code[2:0];
    interleaveSel = il; isWrite = wr; singleWrite = sw;
    advance = adv; terminate = term;
    if (st) begin
      mValid = 1; mStart = col; mBeat = 0;
      mFull = (code == 7) && !(wr && sw);
      mLen = (wr && sw) ? 1 : (mFull ? 256 : codeLen(code));
      mIl = il && !mFull;
    end else if (mValid) begin
      if (term) mValid = 0;
      else if (adv) begin
        if (!mFull && mBeat == mLen - 1) mValid = 0;
        else mBeat = (mBeat + 1) % mLen;
      end
    end
    @(posedge clk);
    #1;
    check(tag, int'(colValid), int'(mValid), "colValid");
    if (mValid) begin
      check(tag, int'(colOut), expCol(mStart, mLen, mFull, mIl, mBeat), "colOut");
      check(tag, int'(lastBeat), int'(!mFull && mBeat == mLen - 1), "lastBeat");
    end
  endtask

  task automatic runAdv(int n, string tag);
    for (int i = 0; i < n; i++) stepCyc(0, 0, 0, 0, 0, 0, 1, 0, tag);
  endtask

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(posedge clk);
    #1;
    check("R1", int'(colValid), 0, "colValid in reset");
    @(negedge clk) rstN = 1'b1;
    @(posedge clk); #1;
    check("R1", int'(colValid), 0, "colValid after reset");
    check("R1", int'(lastBeat), 0, "lastBeat after reset");

    // R3 sequential length 4 from 0x15: 15,16,17,14
    stepCyc(1, 8'h15, 2, 0, 0, 0, 0, 0, "R3");
    runAdv(4, "R3");
    // R3 length 8 sequential wrapping inside group
    stepCyc(1, 8'hC6, 3, 0, 0, 0, 0, 0, "R3");
    runAdv(8, "R3");
    // R4 interleaved length 8 and 4
    stepCyc(1, 8'h2D, 3, 1, 0, 0, 0, 0, "R4");
    runAdv(8, "R4");
    stepCyc(1, 8'h93, 2, 1, 0, 0, 1, 0, "R4");
    runAdv(4, "R4");
    // R5 hold without advance
    stepCyc(1, 8'h40, 3, 0, 0, 0, 0, 0, "R5");
    stepCyc(0, 0, 0, 0, 0, 0, 1, 0, "R5");
    for (int i = 0; i < 3; i++) stepCyc(0, 0, 0, 0, 0, 0, 0, 0, "R5");
    runAdv(7, "R5");
    // R6 length 2 ends, then length 1
    stepCyc(1, 8'h7F, 1, 0, 0, 0, 0, 0, "R6");
    runAdv(3, "R6");
    stepCyc(1, 8'h08, 0, 0, 0, 0, 0, 0, "R6");
    runAdv(2, "R6");
    // R7 full page across the 255 -> 0 wrap, interleave ignored
    stepCyc(1, 8'hFA, 7, 1, 0, 0, 0, 0, "R7");
    runAdv(300, "R7");
    stepCyc(0, 0, 0, 0, 0, 0, 0, 1, "R8");
    // R8 terminate mid burst
    stepCyc(1, 8'h50, 3, 0, 0, 0, 1, 0, "R8");
    runAdv(2, "R8");
    stepCyc(0, 0, 0, 0, 0, 0, 1, 1, "R8");
    stepCyc(0, 0, 0, 0, 0, 0, 1, 0, "R8");
    // R9 restart mid burst, with terminate, and on the last beat
    stepCyc(1, 8'h60, 3, 0, 0, 0, 1, 0, "R9");
    runAdv(2, "R9");
    stepCyc(1, 8'hA1, 2, 1, 0, 0, 1, 1, "R9");
    runAdv(3, "R9");
    stepCyc(1, 8'h05, 1, 0, 0, 0, 1, 0, "R9");
    runAdv(2, "R9");
    // R10 single write versus read with the same setting
    stepCyc(1, 8'h33, 3, 0, 1, 1, 0, 0, "R10");
    runAdv(2, "R10");
    stepCyc(1, 8'h33, 7, 0, 1, 1, 0, 0, "R10");
    runAdv(1, "R10");
    stepCyc(1, 8'h33, 3, 0, 0, 1, 0, 0, "R10");
    runAdv(8, "R10");
    // R2 reserved code gives one beat
    stepCyc(1, 8'hEE, 5, 0, 0, 0, 0, 0, "R2");
    runAdv(2, "R2");

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      int codes[6] = '{0, 1, 2, 3, 7, 5};
      bit st = ($urandom % 100) < 8;
      bit adv = ($urandom % 100) < 75;
      bit term = ($urandom % 100) < 4;
      int code = codes[$urandom % 6];
      string tag;
      tag = (st && code == 7) || (!st && mFull) ? "R7" :
            ((st ? ($urandom % 2) : mIl) ? "R4" : "R3");
      stepCyc(st, $urandom % 256, code, $urandom % 2, $urandom % 2,
              ($urandom % 4) == 0, adv, term, tag);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule